// File: doc/BRIEF.md
# Address-Pattern Bank Switch Unlock

This block sits beside a byte-wide memory that is split into 32 KB banks and decides which bank, if any, answers on a shared bus. It never sees data. It watches the read cycles the host performs and four upper address lines. Host software can change the active bank only by performing a fixed run of sixteen reads whose upper address lines spell out an unlock code. The last steps of that run also carry the bank number or a "deselect everything" command. Any other read traffic leaves the current selection untouched.

Each read cycle reaches the block as a one-clock strobe that has already been synchronized, qualified by chip enable low and write enable high. A sequencer tracks how far into the code the host has got. A compare stage checks each read against the expected code for that step. A bank register holds the outcome and changes only when a complete, fully matching run ends. After reset no bank is active, so several such units can share one bus without conflict.

The sequencer is a three-state machine. In IDLE it is not armed. An all-ones read makes the transition ARM and moves it to ARMED. In ARMED the next read is compared against step 0. A match makes the transition START, which goes to TRACK with step 1. An all-ones read makes the transition REARM, which stays in ARMED. Any other read makes the transition DROP, which goes back to IDLE. In TRACK each matching read makes the transition ADVANCE, which moves the step up by one. A matching read at step 15 makes the transition COMMIT, which goes to IDLE and updates the bank register. A failing read makes the transition REARM if it is all ones and DROP otherwise.

Top module: `bank_switch_unlock`

## Requirements
- R1: While reset is asserted, and on the clock after it is released, `bank_act` is 0, `bank_num` is 0, `dbg_armed` is 0 and `dbg_step` is 0.
- R2: `addr_hi` bit 0 is A8, bit 1 is A9, bit 2 is A10 and bit 3 is A11. A strobed read with `addr_hi` = 4'hF arms the sequencer from any state. On the next clock `dbg_armed` = 1 and `dbg_step` = 0.
- R3: Cycles with `rd_stb` = 0 change neither the sequencer position nor the bank outputs, whatever `addr_hi` holds.
- R4: A9 and A11 must each equal, for steps 0 through 15 in order, 0 1 0 1 1 1 0 0 1 0 1 0 0 0 1 1, and A10 must equal the complement of that list. After a matching read at step k below 15, `dbg_step` reads k+1.
- R5: For steps 0 through 10, A8 must equal 1 0 1 0 0 0 1 1 0 1 0 in that order. From step 11 on, A8 is not part of the match.
- R6: A read that fails the match for the current step sends the sequencer to IDLE (`dbg_armed` = 0, `dbg_step` = 0), unless that read is 4'hF, in which case it re-arms at step 0.
- R7: If A8 is 0 at step 11, a completed run deselects all banks.
- R8: If A8 is 1 at step 11, the A8 values at steps 12, 13, 14 and 15 form the bank number, most significant bit first. The new selection appears on the clock after the sixteenth strobe and not before.
- R9: The bank outputs keep their value until a run completes. Aborted, partial or unarmed runs leave them unchanged.
- R10: A completed run whose bank number is at or above `NUM_BANKS` (2, 4, 8, 12 or 16) deselects all banks.
- R11: Whenever `bank_act` is 0, `bank_num` is 0.
- R12: After a completed run the sequencer is in IDLE. A strobe in the very next clock is evaluated normally, so runs may follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, standing in for power-up |
| rd_stb | input | 1 | One-clock pulse per synchronized read cycle |
| addr_hi | input | 4 | Address lines A11..A8 (bit 0 = A8) |
| bank_num | output | 4 | Selected bank, 0 when none is active |
| bank_act | output | 1 | A bank is selected |
| dbg_armed | output | 1 | Sequencer is in ARMED or TRACK |
| dbg_step | output | 4 | Step the next read is compared against |

## Verification
The bench runs every combination of the step-11 enable bit and the 4-bit bank number through complete runs on a 12-bank configuration. This separates selection, explicit deselection and out-of-range deselection. Some of these runs are back-to-back and some have idle clocks between the reads. For each step and each wrong nibble, a run is broken at that step with that nibble, which shows whether a failing read drops to idle or re-arms (the 4'hF case). Each broken run is then continued to show that it cannot disturb the current bank. Strobe-free address activity and a reset taken with a bank selected round out the cases.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

    // Length of the unlock run and width of its step counter.
    localparam int STEPS    = 16;
    localparam int STEP_W   = $clog2(STEPS);
    // First step where A8 carries a command instead of code.
    localparam int SEL_STEP = 11;
    localparam int NIB_W    = 4;
    localparam int BANK_W   = STEPS - SEL_STEP - 1;

    // A9 (and A11) value per step, bit k belongs to step k.
    // A10 is its complement; A8 is also its complement before SEL_STEP.
    localparam logic [STEPS-1:0] MID_CODE = 16'b1100_0101_0011_1010;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRACK = 2'd2
    } seq_state_t;

    // Expected {A11,A10,A9,A8} for a given step.
    function automatic logic [NIB_W-1:0] step_code(input logic [STEP_W-1:0] k);
        logic b;
        b = MID_CODE[k];
        return {b, ~b, b, ~b};
    endfunction

    // Which of the four lines are compared at a given step.
    function automatic logic [NIB_W-1:0] step_mask(input logic [STEP_W-1:0] k);
        if (int'(k) < SEL_STEP)
            return 4'b1111;
        return 4'b1110;
    endfunction

endpackage

// File: rtl/bsw_step_match.sv
module bsw_step_match
    import bsw_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [NIB_W-1:0]  nib,
    output logic              hit,
    output logic              ones
);

    logic [NIB_W-1:0] expect_code;
    logic [NIB_W-1:0] care;
    logic [NIB_W-1:0] diff;

    always_comb begin
        expect_code = step_code(step);
        care        = step_mask(step);
        diff        = (nib ^ expect_code) & care;
        hit         = (diff == '0);
        ones        = &nib;
    end

    // Every code step has A9 equal to A11 and A10 opposite, so all-ones can never match.
    always_comb begin
        if (ones) begin
            AST_ONES_NEVER_HIT: assert (!hit); // R6
        end
    end

endmodule

// File: rtl/bsw_seq_fsm.sv
module bsw_seq_fsm
    import bsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              hit,
    input  logic              ones,
    input  logic              a8,
    output seq_state_t        state,
    output logic [STEP_W-1:0] step,
    output logic              commit,
    output logic              cmd_en,
    output logic [BANK_W-1:0] cmd_num
);

    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(STEPS - 1);
    localparam logic [STEP_W-1:0] EN_STEP    = STEP_W'(SEL_STEP);

    seq_state_t        state_nx;
    logic [STEP_W-1:0] step_nx;
    logic              sel_en;
    logic [BANK_W-2:0] sel_bits;
    logic              take;

    // A read that matches while tracking.
    assign take = rd_stb && (state == ST_TRACK) && hit;

    // State register and command capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            sel_en   <= 1'b0;
            sel_bits <= '0;
        end else begin
            state <= state_nx;
            step  <= step_nx;
            if (take && step == EN_STEP)
                sel_en <= a8;
            if (take && step > EN_STEP && step < LAST_STEP)
                sel_bits <= {sel_bits[BANK_W-3:0], a8};
        end
    end

    // Transitions: ARM, START, REARM, DROP, ADVANCE, COMMIT.
    always_comb begin
        state_nx = state;
        step_nx  = step;
        if (rd_stb) begin
            unique case (state)
                ST_IDLE: begin
                    if (ones) begin           // ARM
                        state_nx = ST_ARMED;
                        step_nx  = '0;
                    end
                end
                ST_ARMED: begin
                    if (hit) begin            // START
                        state_nx = ST_TRACK;
                        step_nx  = STEP_W'(1);
                    end else if (ones) begin  // REARM
                        state_nx = ST_ARMED;
                        step_nx  = '0;
                    end else begin            // DROP
                        state_nx = ST_IDLE;
                        step_nx  = '0;
                    end
                end
                ST_TRACK: begin
                    if (hit && step == LAST_STEP) begin  // COMMIT
                        state_nx = ST_IDLE;
                        step_nx  = '0;
                    end else if (hit) begin              // ADVANCE
                        step_nx  = step + STEP_W'(1);
                    end else if (ones) begin             // REARM
                        state_nx = ST_ARMED;
                        step_nx  = '0;
                    end else begin                       // DROP
                        state_nx = ST_IDLE;
                        step_nx  = '0;
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                    step_nx  = '0;
                end
            endcase
        end
    end

    // Outputs toward the bank register.
    always_comb begin
        commit  = take && (step == LAST_STEP);
        cmd_en  = sel_en;
        cmd_num = {sel_bits, a8};
    end

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(state) && $stable(step)); // R3

    AST_ONES_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && ones |=> (state == ST_ARMED) && (step == '0)); // R2

    AST_MISMATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && (state != ST_IDLE) && !hit && !ones |=> (state == ST_IDLE) && (step == '0)); // R6

    AST_COMMIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == ST_IDLE)); // R12

    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        take && (step != LAST_STEP) |=> (step == $past(step) + STEP_W'(1))); // R4

endmodule

// File: rtl/bsw_bank_reg.sv
module bsw_bank_reg
    import bsw_pkg::*;
#(
    parameter int NUM_BANKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              cmd_en,
    input  logic [BANK_W-1:0] cmd_num,
    output logic [BANK_W-1:0] bank_num,
    output logic              bank_act
);

    localparam logic [BANK_W:0] LIMIT = (BANK_W + 1)'(NUM_BANKS);

    logic in_range;

    assign in_range = ({1'b0, cmd_num} < LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_num <= '0;
            bank_act <= 1'b0;
        end else if (commit) begin
            if (cmd_en && in_range) begin
                bank_num <= cmd_num;
                bank_act <= 1'b1;
            end else begin
                bank_num <= '0;
                bank_act <= 1'b0;
            end
        end
    end

    AST_HOLD_BETWEEN_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(bank_num) && $stable(bank_act)); // R9

    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_act |-> ({1'b0, bank_num} < LIMIT)); // R10

    AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_act |-> (bank_num == '0)); // R11

    AST_DESELECT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !cmd_en |=> !bank_act); // R7

endmodule

// File: rtl/bank_switch_unlock.sv
module bank_switch_unlock
    import bsw_pkg::*;
#(
    parameter int NUM_BANKS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_stb,
    input  logic [3:0]  addr_hi,
    output logic [3:0]  bank_num,
    output logic        bank_act,
    output logic        dbg_armed,
    output logic [3:0]  dbg_step
);

    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic              hit;
    logic              ones;
    logic              commit;
    logic              cmd_en;
    logic [BANK_W-1:0] cmd_num;

    initial begin
        AST_BANK_COUNT_LEGAL: assert (NUM_BANKS == 2 || NUM_BANKS == 4 || NUM_BANKS == 8 ||
                                      NUM_BANKS == 12 || NUM_BANKS == 16); // R10
    end

    bsw_step_match u_match (
        .step (step),
        .nib  (addr_hi),
        .hit  (hit),
        .ones (ones)
    );

    bsw_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .hit     (hit),
        .ones    (ones),
        .a8      (addr_hi[0]),
        .state   (state),
        .step    (step),
        .commit  (commit),
        .cmd_en  (cmd_en),
        .cmd_num (cmd_num)
    );

    bsw_bank_reg #(.NUM_BANKS(NUM_BANKS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .cmd_en   (cmd_en),
        .cmd_num  (cmd_num),
        .bank_num (bank_num),
        .bank_act (bank_act)
    );

    assign dbg_armed = (state != ST_IDLE);
    assign dbg_step  = step;

    AST_IDLE_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_armed |-> (dbg_step == 4'd0)); // R6

    AST_NO_EARLY_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && dbg_armed && dbg_step == 4'd15) |=> $stable(bank_act)); // R8

endmodule

// File: tb/tb_bank_switch_unlock.sv
module tb_bank_switch_unlock;

    localparam int NB = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_stb = 1'b0;
    logic [3:0] addr_hi = 4'h0;
    logic [3:0] bank_num;
    logic       bank_act;
    logic       dbg_armed;
    logic [3:0] dbg_step;

    int n_chk = 0;
    int n_bad = 0;

    // Expected model of the bank outputs.
    logic       m_act = 1'b0;
    logic [3:0] m_num = 4'h0;

    // Code lists from the requirements.
    int mid_l[16] = '{0,1,0,1,1,1,0,0,1,0,1,0,0,0,1,1};
    int low_l[11] = '{1,0,1,0,0,0,1,1,0,1,0};

    bank_switch_unlock #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .addr_hi(addr_hi),
        .bank_num(bank_num), .bank_act(bank_act),
        .dbg_armed(dbg_armed), .dbg_step(dbg_step)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] code(input int k, input logic a8);
        logic m;
        m = mid_l[k][0];
        if (k < 11) return {m, ~m, m, low_l[k][0]};
        return {m, ~m, m, a8};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobed read; returns at the negedge after the capturing edge.
    task automatic rd(input logic [3:0] nib);
        rd_stb  = 1'b1;
        addr_hi = nib;
        @(negedge clk);
        rd_stb  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_bank(input string req);
        chk(req, int'(bank_act), int'(m_act));
        chk(req, int'(bank_num), int'(m_num));
    endtask

    // Full run with command bits; gap inserts an idle clock after each read.
    task automatic run(input logic en, input logic [3:0] num, input logic gap);
        logic a8;
        rd(4'hF);
        chk("R2", int'(dbg_armed), 1);
        for (int k = 0; k < 16; k++) begin
            if (k < 11)       a8 = 1'b0;
            else if (k == 11) a8 = en;
            else              a8 = num[15 - k];
            if (k == 15) chk_bank("R8 before last");
            rd(code(k, a8));
            if (k < 15) chk("R4 step", int'(dbg_step), k + 1);
            if (gap) idle(1);
        end
        if (en && int'(num) < NB) begin
            m_act = 1'b1; m_num = num;
        end else begin
            m_act = 1'b0; m_num = 4'h0;
        end
        chk_bank(!en ? "R7" : (int'(num) >= NB ? "R10" : "R8"));
        chk("R12 idle", int'(dbg_armed), 0);
        if (!bank_act) chk("R11", int'(bank_num), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset values.
        chk("R1", int'(bank_act), 0);
        chk("R1", int'(bank_num), 0);
        chk("R1", int'(dbg_armed), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(dbg_armed), 0);
        chk("R1", int'(dbg_step), 0);

        // R3: address activity without strobes.
        for (int i = 0; i < 16; i++) begin
            addr_hi = 4'(i);
            @(negedge clk);
        end
        addr_hi = 4'hF;
        idle(2);
        chk("R3", int'(dbg_armed), 0);
        rd(4'hF);
        addr_hi = code(0, 1'b0);
        idle(2);
        chk("R3 no strobe", int'(dbg_step), 0);
        chk("R3 no strobe", int'(dbg_armed), 1);

        // R7 R8 R10 R11: every command, alternate spacing.
        for (int e = 0; e < 2; e++)
            for (int n = 0; n < 16; n++)
                run(e[0], 4'(n), n[0]);

        // R12: two runs with no gap between them.
        run(1'b1, 4'd3, 1'b0);
        run(1'b1, 4'd9, 1'b0);

        // R4 R5 R6 R9: break a run at every step with every failing nibble.
        run(1'b1, 4'd5, 1'b0);
        for (int k = 0; k < 16; k++) begin
            for (int v = 0; v < 16; v++) begin
                logic [3:0] good;
                logic [3:0] mask;
                good = code(k, 1'b0);
                mask = (k < 11) ? 4'hF : 4'hE;
                if (((4'(v) ^ good) & mask) == 4'h0) continue;
                rd(4'hF);
                for (int j = 0; j < k; j++) rd(code(j, 1'b1));
                rd(4'(v));
                chk(k < 11 ? "R5 R6 break" : "R4 R6 break", int'(dbg_armed), (v == 15) ? 1 : 0);
                chk("R6 step", int'(dbg_step), 0);
                for (int j = k + 1; j < 16; j++) rd(code(j, 1'b1));
                chk_bank("R9 after break");
            end
        end

        // R1: reset with a bank selected.
        run(1'b1, 4'd7, 1'b0);
        rst_n = 1'b0;
        idle(2);
        chk("R1 reapply", int'(bank_act), 0);
        chk("R1 reapply", int'(bank_num), 0);
        rst_n = 1'b1;
        m_act = 1'b0; m_num = 4'h0;
        idle(1);
        run(1'b1, 4'd11, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule